// File: doc/BRIEF.md
# CAN Transmit Buffer Scheduler

This block decides which message buffer a CAN controller sends next. Up to fifteen buffers, numbered 0 to 14, each raise a transmit request and supply a 4-bit priority field. The scheduler forms an 8-bit key for each requester. The priority field is the upper nibble and the buffer number is the lower nibble. The requester with the smallest key wins. The winner is held as the "pick". The buffer state machines see it as busy, and at that point it may still be displaced.

The pick may change only while the selection window is open. The window is open while the bus is idle, and from the CRC-field strobe of the frame on the bus until the next frame starts. So a frame can follow the one on the bus back to back, while a late, better request or a CPU cancel can still alter the choice. A displaced pick gets a one-cycle override pulse, which sends it back to pending. A transmit failure or lost arbitration closes the window and releases both the current and the scheduled buffer. Selection resumes only once the bit engine reports that the intervening error signalling or reception has ended.

The bit engine supplies only timing strobes: frame start, CRC start, frame end, abort and recovery done. The scheduler returns the pick, the buffer currently on the bus, a per-buffer busy mask, override pulses and a start pulse.

Top module: `tx_sched_top`

## Requirements
- R1: After a synchronous active-low reset, no pick and no current buffer are held. The busy mask and the override vector are zero, start is low and the window is open (bus idle).
- R2: With the window open, the pick registered at each edge is the requester with the smallest key {priority[3:0], buffer number[3:0]}. For example, priority 14 on buffer 0 (key 224) loses to priority 0 on buffer 14 (key 14).
- R3: Requesters with equal priority fields are resolved in favour of the lower buffer number.
- R4: While the bus is idle, a request raised before an edge is the pick right after that edge.
- R5: Between frame start and the CRC strobe, and while recovering from an abort, the window is closed and no pick is made, whatever the requests.
- R6: The CRC strobe opens the window. From the following edge a pick is made, and the buffer on the bus is excluded even if its request is still raised.
- R7: When a better requester displaces a pick whose request is still raised, the displaced buffer gets a one-cycle bit on the override vector (bit i for buffer i).
- R8: When the picked buffer's request is dropped (CPU cancel), the pick moves to the next best requester, or becomes empty, and no override bit is raised for it.
- R9: A frame-start strobe while a pick is held gives a one-cycle start pulse. It makes the pick the current buffer, empties the pick and closes the window.
- R10: A frame-end strobe inside the window releases the current buffer. If no requester remains, the block returns to the idle (open) state.
- R11: An abort during a frame or window raises override bits for the current buffer and the pick, releases both and closes the window. Selection resumes one edge after the recovery-done strobe.
- R12: A frame-start strobe with no pick held has no effect: no start pulse and no current buffer.
- R13: At most two buffers are busy at once, and at most one while the window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 15 | Transmit request per buffer |
| txpri_i | input | 60 | 4-bit priority field per buffer, buffer i at [4i+3:4i] |
| frame_start_i | input | 1 | Strobe: next frame starts on the bus |
| crc_start_i | input | 1 | Strobe: CRC field of the current frame begins |
| frame_end_i | input | 1 | Strobe: current frame completed successfully |
| tx_abort_i | input | 1 | Strobe: transmit error or lost arbitration |
| recover_done_i | input | 1 | Strobe: error signalling or reception finished |
| pick_vld_o | output | 1 | A buffer is scheduled for the next frame |
| pick_idx_o | output | 4 | Scheduled buffer number |
| cur_vld_o | output | 1 | A buffer is on the bus |
| cur_idx_o | output | 4 | Buffer number on the bus |
| busy_o | output | 15 | Per-buffer busy flag (current or scheduled) |
| ovr_o | output | 15 | One-cycle override pulse per buffer, back to pending |
| start_o | output | 1 | One-cycle pulse when the pick becomes current |
| win_open_o | output | 1 | Selection window is open |

## Verification
The bench sets two buffers with equal priority fields, so a design that ignored the buffer-number nibble would pick the wrong one. It also keeps the current buffer's request raised through its own CRC window, so a design that forgot the exclusion would schedule the buffer already on the bus. It cancels a pick and, separately, displaces one with a better requester. A design that treated the two alike would raise a spurious override or miss the required one. Aborts, frame starts without a pick, and a frame end with an empty queue show up designs that keep selecting while closed, start phantom frames, or stay stuck in the window.

// File: rtl/tx_sched_pkg.sv
// Package: shared phase encoding for the transmit scheduler.
// Assumes: one scheduler phase register per controller.
package tx_sched_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // bus idle, window open
        PH_FRAME  = 2'd1,   // frame on bus before CRC, window closed
        PH_WINDOW = 2'd2,   // CRC reached, window open until next start
        PH_HOLD   = 2'd3    // after abort, waiting for recovery
    } sched_phase_e;

    // True when the phase permits (re)selection of the pick.
    function automatic logic phase_open(input sched_phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_WINDOW);
    endfunction

endpackage

// File: rtl/txs_min_search.sv
// Module: combinational minimum search over composite transmit keys.
// Each candidate key is {priority field, buffer number}; smallest wins.
// Assumes: buffer numbers fit in IDX_W bits, so keys are unique.
module txs_min_search #(
    parameter int NUM_BUF = 15,
    parameter int PRI_W   = 4,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_BUF-1:0]       cand_i,
    input  logic [NUM_BUF*PRI_W-1:0] pri_i,
    output logic                     win_vld_o,
    output logic [IDX_W-1:0]         win_idx_o
);

    localparam int KEY_W = PRI_W + IDX_W;

    logic [KEY_W-1:0] key [NUM_BUF];

    // Build one composite key per buffer.
    generate
        for (genvar g = 0; g < NUM_BUF; g++) begin : g_key
            assign key[g] = {pri_i[g*PRI_W +: PRI_W], IDX_W'(g)};
        end
    endgenerate

    // Scan candidates and keep the smallest key seen.
    always_comb begin
        logic [KEY_W-1:0] best_key;
        best_key  = '1;
        win_vld_o = 1'b0;
        win_idx_o = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (cand_i[i] && (!win_vld_o || key[i] < best_key)) begin
                win_vld_o = 1'b1;
                best_key  = key[i];
                win_idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/txs_phase_ctrl.sv
// Module: bus-phase tracker for the scheduler window.
// Turns bit-engine strobes into the accepted start/end/abort events and
// the open/closed state of the selection window.
// Assumes: strobes are single-cycle; abort outranks every other strobe.
module txs_phase_ctrl
    import tx_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start_i,
    input  logic crc_start_i,
    input  logic frame_end_i,
    input  logic tx_abort_i,
    input  logic recover_done_i,
    input  logic pick_vld_i,
    input  logic next_pick_vld_i,
    output logic win_open_o,
    output logic abort_acc_o,
    output logic start_acc_o,
    output logic end_acc_o
);

    sched_phase_e phase_q, phase_d;

    // Qualify the strobes against the present phase.
    always_comb begin
        win_open_o  = phase_open(phase_q);
        abort_acc_o = tx_abort_i && (phase_q == PH_FRAME || phase_q == PH_WINDOW);
        start_acc_o = !abort_acc_o && frame_start_i && pick_vld_i && win_open_o;
        end_acc_o   = !abort_acc_o && !start_acc_o && frame_end_i &&
                      (phase_q == PH_WINDOW);
    end

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        if (abort_acc_o) begin
            phase_d = PH_HOLD;
        end else if (start_acc_o) begin
            phase_d = PH_FRAME;
        end else begin
            unique case (phase_q)
                PH_FRAME:  if (crc_start_i)    phase_d = PH_WINDOW;
                PH_HOLD:   if (recover_done_i) phase_d = PH_IDLE;
                PH_WINDOW: if (end_acc_o && !next_pick_vld_i) phase_d = PH_IDLE;
                default:   phase_d = phase_q;
            endcase
        end
    end

    // Phase register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/txs_slot_regs.sv
// Module: holds the scheduled (pick) and on-bus (current) buffer slots,
// and issues override and start pulses to the buffer state machines.
// Assumes: the accepted events come from txs_phase_ctrl, one per cycle.
module txs_slot_regs #(
    parameter int NUM_BUF = 15,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] req_i,
    input  logic               win_open_i,
    input  logic               abort_acc_i,
    input  logic               start_acc_i,
    input  logic               end_acc_i,
    input  logic               win_vld_i,
    input  logic [IDX_W-1:0]   win_idx_i,
    output logic               pick_vld_o,
    output logic [IDX_W-1:0]   pick_idx_o,
    output logic               cur_vld_o,
    output logic [IDX_W-1:0]   cur_idx_o,
    output logic [NUM_BUF-1:0] cur_mask_o,
    output logic [NUM_BUF-1:0] busy_o,
    output logic [NUM_BUF-1:0] ovr_o,
    output logic               start_o
);

    logic [NUM_BUF-1:0] pick_mask;
    logic               pick_vld_d, cur_vld_d, start_d;
    logic [IDX_W-1:0]   pick_idx_d, cur_idx_d;
    logic [NUM_BUF-1:0] ovr_d;
    logic               pick_still_req;

    // Decode the two slots into per-buffer masks.
    generate
        for (genvar g = 0; g < NUM_BUF; g++) begin : g_mask
            assign pick_mask[g]  = pick_vld_o && (pick_idx_o == IDX_W'(g));
            assign cur_mask_o[g] = cur_vld_o  && (cur_idx_o  == IDX_W'(g));
        end
    endgenerate

    assign busy_o         = pick_mask | cur_mask_o;
    assign pick_still_req = |(pick_mask & req_i);

    // Next values of both slots and the pulse outputs.
    always_comb begin
        pick_vld_d = pick_vld_o;
        pick_idx_d = pick_idx_o;
        cur_vld_d  = cur_vld_o;
        cur_idx_d  = cur_idx_o;
        ovr_d      = '0;
        start_d    = 1'b0;
        if (abort_acc_i) begin
            ovr_d      = busy_o;
            pick_vld_d = 1'b0;
            cur_vld_d  = 1'b0;
        end else if (start_acc_i) begin
            start_d    = 1'b1;
            cur_vld_d  = 1'b1;
            cur_idx_d  = pick_idx_o;
            pick_vld_d = 1'b0;
        end else begin
            if (win_open_i) begin
                if (pick_still_req && (!win_vld_i || win_idx_i != pick_idx_o))
                    ovr_d = pick_mask;
                pick_vld_d = win_vld_i;
                pick_idx_d = win_vld_i ? win_idx_i : pick_idx_o;
            end
            if (end_acc_i) cur_vld_d = 1'b0;
        end
    end

    // Slot and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_vld_o <= 1'b0;
            pick_idx_o <= '0;
            cur_vld_o  <= 1'b0;
            cur_idx_o  <= '0;
            ovr_o      <= '0;
            start_o    <= 1'b0;
        end else begin
            pick_vld_o <= pick_vld_d;
            pick_idx_o <= pick_idx_d;
            cur_vld_o  <= cur_vld_d;
            cur_idx_o  <= cur_idx_d;
            ovr_o      <= ovr_d;
            start_o    <= start_d;
        end
    end

endmodule

// File: rtl/tx_sched_top.sv
// Module: CAN transmit scheduler top.
// Chooses the next buffer by smallest {priority, number} key during the
// selection window and hands it to the buffer state machines.
// Assumes: bit-engine strobes are single-cycle and synchronous to clk.
module tx_sched_top #(
    parameter int NUM_BUF = 15,
    parameter int PRI_W   = 4,
    parameter int IDX_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_BUF-1:0]       req_i,
    input  logic [NUM_BUF*PRI_W-1:0] txpri_i,
    input  logic                     frame_start_i,
    input  logic                     crc_start_i,
    input  logic                     frame_end_i,
    input  logic                     tx_abort_i,
    input  logic                     recover_done_i,
    output logic                     pick_vld_o,
    output logic [IDX_W-1:0]         pick_idx_o,
    output logic                     cur_vld_o,
    output logic [IDX_W-1:0]         cur_idx_o,
    output logic [NUM_BUF-1:0]       busy_o,
    output logic [NUM_BUF-1:0]       ovr_o,
    output logic                     start_o,
    output logic                     win_open_o
);

    logic [NUM_BUF-1:0] cur_mask;
    logic [NUM_BUF-1:0] cand;
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;
    logic               abort_acc, start_acc, end_acc;

    // The buffer on the bus never competes for the next slot.
    assign cand = req_i & ~cur_mask;

    txs_min_search #(
        .NUM_BUF (NUM_BUF),
        .PRI_W   (PRI_W),
        .IDX_W   (IDX_W)
    ) u_search (
        .cand_i    (cand),
        .pri_i     (txpri_i),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx)
    );

    txs_phase_ctrl u_phase (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_start_i   (frame_start_i),
        .crc_start_i     (crc_start_i),
        .frame_end_i     (frame_end_i),
        .tx_abort_i      (tx_abort_i),
        .recover_done_i  (recover_done_i),
        .pick_vld_i      (pick_vld_o),
        .next_pick_vld_i (win_vld),
        .win_open_o      (win_open_o),
        .abort_acc_o     (abort_acc),
        .start_acc_o     (start_acc),
        .end_acc_o       (end_acc)
    );

    txs_slot_regs #(
        .NUM_BUF (NUM_BUF),
        .IDX_W   (IDX_W)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .win_open_i  (win_open_o),
        .abort_acc_i (abort_acc),
        .start_acc_i (start_acc),
        .end_acc_i   (end_acc),
        .win_vld_i   (win_vld),
        .win_idx_i   (win_idx),
        .pick_vld_o  (pick_vld_o),
        .pick_idx_o  (pick_idx_o),
        .cur_vld_o   (cur_vld_o),
        .cur_idx_o   (cur_idx_o),
        .cur_mask_o  (cur_mask),
        .busy_o      (busy_o),
        .ovr_o       (ovr_o),
        .start_o     (start_o)
    );

endmodule

// File: rtl/tx_sched_chk.sv
// Module: property checker for tx_sched_top, attached by bind below.
// Assumes: synchronous active-low reset; observes ports only.
module tx_sched_chk #(
    parameter int NUM_BUF = 15,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUF-1:0] req_i,
    input logic               pick_vld_o,
    input logic [IDX_W-1:0]   pick_idx_o,
    input logic               cur_vld_o,
    input logic [IDX_W-1:0]   cur_idx_o,
    input logic [NUM_BUF-1:0] busy_o,
    input logic [NUM_BUF-1:0] ovr_o,
    input logic               start_o,
    input logic               win_open_o
);

    AST_PICK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld_o |-> ((($past(req_i) >> pick_idx_o) & NUM_BUF'(1)) != '0)); // R2

    AST_CLOSED_NO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open_o |-> !pick_vld_o); // R5

    AST_PICK_NOT_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld_o && cur_vld_o) |-> (pick_idx_o != cur_idx_o)); // R6

    AST_OVR_WAS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o != '0) |-> (($past(busy_o) & ovr_o) == ovr_o)); // R7

    AST_START_FROM_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($past(pick_vld_o) && cur_vld_o && cur_idx_o == $past(pick_idx_o))); // R9

    AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_o) <= 2); // R13

    AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open_o |-> ($countones(busy_o) <= 1)); // R13

endmodule

bind tx_sched_top tx_sched_chk #(
    .NUM_BUF (NUM_BUF),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .pick_vld_o (pick_vld_o),
    .pick_idx_o (pick_idx_o),
    .cur_vld_o  (cur_vld_o),
    .cur_idx_o  (cur_idx_o),
    .busy_o     (busy_o),
    .ovr_o      (ovr_o),
    .start_o    (start_o),
    .win_open_o (win_open_o)
);

// File: tb/tb_tx_sched_top.sv
module tb_tx_sched_top;

    localparam int NB = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] req = '0;
    logic [NB*4-1:0] txpri = '0;
    logic fs = 1'b0, crc = 1'b0, fe = 1'b0, ab = 1'b0, rd = 1'b0;

    logic          pick_vld, cur_vld, start, win_open;
    logic [3:0]    pick_idx, cur_idx;
    logic [NB-1:0] busy, ovr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tx_sched_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .txpri_i(txpri),
        .frame_start_i(fs), .crc_start_i(crc), .frame_end_i(fe),
        .tx_abort_i(ab), .recover_done_i(rd),
        .pick_vld_o(pick_vld), .pick_idx_o(pick_idx),
        .cur_vld_o(cur_vld), .cur_idx_o(cur_idx),
        .busy_o(busy), .ovr_o(ovr), .start_o(start), .win_open_o(win_open)
    );

    // Behavioural reference: phase 0 idle, 1 frame, 2 window, 3 hold.
    int            m_ph = 0;
    bit            m_pv = 0, m_cv = 0, m_st = 0;
    int            m_pi = 0, m_ci = 0;
    logic [NB-1:0] m_ovr = '0;

    always @(posedge clk) begin
        int  best, bi, key;
        bit  open, abort_ok, start_ok, end_ok;
        if (!rst_n) begin
            m_ph = 0; m_pv = 0; m_cv = 0; m_st = 0; m_pi = 0; m_ci = 0; m_ovr = '0;
        end else begin
            best = 1000; bi = -1;
            for (int i = 0; i < NB; i++) begin
                key = int'(txpri[i*4 +: 4]) * 16 + i;
                if (req[i] && !(m_cv && m_ci == i) && key < best) begin
                    best = key; bi = i;
                end
            end
            open     = (m_ph == 0) || (m_ph == 2);
            abort_ok = ab && (m_ph == 1 || m_ph == 2);
            start_ok = !abort_ok && fs && m_pv && open;
            end_ok   = !abort_ok && !start_ok && fe && (m_ph == 2);
            m_ovr = '0;
            m_st  = start_ok;
            if (abort_ok) begin
                if (m_pv) m_ovr[m_pi] = 1'b1;
                if (m_cv) m_ovr[m_ci] = 1'b1;
                m_pv = 0; m_cv = 0; m_ph = 3;
            end else if (start_ok) begin
                m_cv = 1; m_ci = m_pi; m_pv = 0; m_ph = 1;
            end else begin
                if (open) begin
                    if (m_pv && req[m_pi] && bi != m_pi) m_ovr[m_pi] = 1'b1;
                    m_pv = (bi >= 0);
                    if (bi >= 0) m_pi = bi;
                end
                if (m_ph == 1 && crc) m_ph = 2;
                else if (m_ph == 3 && rd) m_ph = 0;
                else if (end_ok) begin
                    m_cv = 0;
                    m_ph = (bi >= 0) ? 2 : 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output against the reference model.
    task automatic compare_all();
        chk(pick_vld == m_pv, "R2 pick_vld", pick_vld, m_pv);
        if (m_pv) chk(pick_idx == 4'(m_pi), "R2 pick_idx", pick_idx, m_pi);
        chk(cur_vld == m_cv, "R9 cur_vld", cur_vld, m_cv);
        if (m_cv) chk(cur_idx == 4'(m_ci), "R9 cur_idx", cur_idx, m_ci);
        chk(ovr == m_ovr, "R7 ovr", ovr, m_ovr);
        chk(start == m_st, "R9 start", start, m_st);
        chk(win_open == (m_ph == 0 || m_ph == 2), "R5 win_open", win_open, (m_ph == 0 || m_ph == 2));
        chk($countones(busy) == int'(m_pv) + int'(m_cv), "R13 busy count",
            $countones(busy), int'(m_pv) + int'(m_cv));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic setb(input int i, input bit r, input int p);
        req[i] = r;
        txpri[i*4 +: 4] = 4'(p);
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1; step(); s = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(!pick_vld && !cur_vld && busy == '0 && ovr == '0 && !start && win_open,
            "R1 reset state", {pick_vld, cur_vld, start, win_open}, 4'b0001);

        // R4 immediate pick on idle bus; R2 smallest key (3:key 83, 7:key 39)
        setb(3, 1, 5); setb(7, 1, 2);
        step();
        chk(pick_vld && pick_idx == 4'd7, "R4 idle pick", pick_idx, 7);

        // R3 equal priority, lower number wins; R7 override for displaced 7
        setb(1, 1, 2);
        step();
        chk(pick_idx == 4'd1, "R3 tie to lower number", pick_idx, 1);
        chk(ovr == 15'h0080, "R7 override displaced", ovr, 15'h0080);
        step();

        // R9 frame start
        strobe(fs);
        chk(start && cur_vld && cur_idx == 4'd1 && !pick_vld && busy == 15'h0002,
            "R9 start handoff", busy, 15'h0002);

        // R5 window closed during frame
        setb(0, 1, 0);
        repeat (3) step();
        chk(!pick_vld && !win_open, "R5 closed before CRC", pick_vld, 0);

        // R6 CRC opens window, current buffer excluded
        strobe(crc);
        step();
        chk(pick_vld && pick_idx == 4'd0 && busy == 15'h0003, "R6 pick after CRC", busy, 15'h0003);

        // R8 cancel of pick, no override
        setb(0, 0, 0);
        step();
        chk(pick_idx == 4'd7 && ovr == '0, "R8 cancel no override", ovr, 0);

        // frame end with a pending pick, then next frame on 7
        setb(1, 0, 2);
        strobe(fe);
        chk(!cur_vld && win_open && pick_idx == 4'd7, "R10 end keeps window", cur_vld, 0);
        strobe(fs);
        strobe(crc);
        step();
        chk(pick_vld && pick_idx == 4'd3, "R6 exclude current 7", pick_idx, 3);

        // R11 abort releases both, holds until recovery
        strobe(ab);
        chk(ovr == 15'h0088 && !pick_vld && !cur_vld && !win_open, "R11 abort override", ovr, 15'h0088);
        repeat (2) step();
        chk(!pick_vld, "R11 no pick while holding", pick_vld, 0);
        strobe(rd);
        step();
        chk(pick_vld && pick_idx == 4'd7, "R11 reselect after recovery", pick_idx, 7);

        // R12 frame start without a pick
        req = '0;
        step();
        strobe(fs);
        chk(!start && !cur_vld, "R12 ignored start", start, 0);

        // R10 frame end with empty queue returns to idle
        setb(7, 1, 2);
        step();
        strobe(fs);
        strobe(crc);
        setb(7, 0, 2);
        strobe(fe);
        chk(!cur_vld && win_open && busy == '0, "R10 idle after end", busy, 0);

        // R2 table example: 224 versus 14
        setb(0, 1, 14); setb(14, 1, 0);
        step();
        chk(pick_idx == 4'd14, "R2 key 14 beats 224", pick_idx, 14);
        req = '0;
        step();

        // Random traffic compared on every clock
        for (int c = 0; c < 4000; c++) begin
            for (int b = 0; b < NB; b++) begin
                if ($urandom_range(0, 9) == 0) req[b] = ~req[b];
                if ($urandom_range(0, 19) == 0) txpri[b*4 +: 4] = 4'($urandom_range(0, 15));
            end
            fs  = ($urandom_range(0, 5) == 0);
            crc = ($urandom_range(0, 5) == 0);
            fe  = ($urandom_range(0, 6) == 0);
            ab  = ($urandom_range(0, 30) == 0);
            rd  = ($urandom_range(0, 4) == 0);
            step();
        end
        {fs, crc, fe, ab, rd} = '0;
        step();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule